// File: doc/BRIEF.md
# Reset and Power-Down Sequencer

This controller brings a synthesizer chip out of deep sleep and through its start-up, and puts it back to sleep on demand. It watches two active-low inputs, a chip reset and a power-down request. From them it drives five outputs: an enable for the crystal oscillator and PLL, a global enable for the pad drivers, a reset for the internal core, a running flag, and a gate that lets MIDI and host messages through.

Power-down acts asynchronously. Lowering it stops the oscillator, floats every pad and holds the core in reset at once. Raising it again does not wake the chip. The sequencer stays asleep until a fresh reset pulse arrives. That pulse must stay low for a programmable stabilisation time so the oscillator and PLL can settle. A pulse that is too short is ignored, and the chip waits for a proper one.

After a valid reset the core runs an initialisation phase of programmable length. The core reset is held for its first few cycles, and messages stay blocked until the phase ends. The machine has four states:
- SLEEP
- WAIT_RESET, where it qualifies the reset pulse
- INIT
- RUN

Its transitions are:
- sleep entry, from any state when power-down is low
- wake, from SLEEP to WAIT_RESET on a reset pulse
- short-pulse reject, from WAIT_RESET back to itself
- qualify, from WAIT_RESET to INIT
- init-done, from INIT to RUN
- restart, from INIT or RUN to WAIT_RESET on a reset pulse

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `pdn_n` is low, `osc_en`, `pad_oe`, `run` and `msg_ok` are 0 and `core_rst` is 1.
- R2: After `pdn_n` returns high, the outputs keep their R1 values until the synchronised reset input has been seen low.
- R3: `rst_in_n` passes through `SYNC_STAGES` flops. A low level seen from SLEEP, INIT or RUN enters WAIT_RESET, where `osc_en` and `pad_oe` are 1, `core_rst` is 1 and `run` is 0.
- R4: A reset low pulse shorter than `STAB_CYCLES` clock cycles is rejected. The block stays in WAIT_RESET with `core_rst` 1 until a later pulse is long enough.
- R5: A reset low pulse of at least `STAB_CYCLES` cycles leads to INIT once it is released. INIT lasts `INIT_CYCLES` cycles, and `core_rst` is 1 for its first `CORE_RST_CYCLES` cycles and 0 afterwards.
- R6: `run` and `msg_ok` are 1 exactly from the end of INIT until the next reset pulse or power-down, and 0 at all other times.
- R7: A reset low level seen in INIT or RUN returns the block to WAIT_RESET, which re-asserts `core_rst` and clears `run`.
- R8: `pdn_n` going low forces SLEEP from any state, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_in_n | input | 1 | Chip reset request, active low, asynchronous to clk |
| pdn_n | input | 1 | Power-down request, active low, asynchronous kill |
| osc_en | output | 1 | Oscillator and PLL enable |
| pad_oe | output | 1 | Global pad output enable (0 floats the pads) |
| core_rst | output | 1 | Internal core reset, active high |
| run | output | 1 | Synthesizer up and running |
| msg_ok | output | 1 | Message acceptance gate |

## Verification
The bench uses reset pulses exactly one cycle below and exactly at the stabilisation limit. A design with an off-by-one qualifier would either start from a pulse that is too short or refuse a legal one. It raises power-down with no reset and expects the chip to stay asleep. A design that woke on the power-down edge alone would enable the oscillator early. It drops power-down in the middle of a clock period and checks the outputs before the next edge, which exposes a synchronous sleep entry. Random pulse lengths, idle gaps and reset or power-down pulses that land inside INIT and RUN are compared cycle by cycle against a bench model. That comparison catches a wrong core-reset window, a wrong INIT length or a missed restart.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP    = 2'd0,
        ST_WAIT_RST = 2'd1,
        ST_INIT     = 2'd2,
        ST_RUN      = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        T_HOLD  = 2'd0,
        T_CLEAR = 2'd1,
        T_START = 2'd2,
        T_STEP  = 2'd3
    } tmr_op_t;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d};
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer
    import pwr_seq_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int MAX   = 200
) (
    input  logic             clk,
    input  logic             arst_n,
    input  tmr_op_t          op,
    output logic [WIDTH-1:0] cnt
);
    localparam logic [WIDTH-1:0] LIM = WIDTH'(MAX);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                T_HOLD:  cnt_q <= cnt_q;
                T_CLEAR: cnt_q <= '0;
                T_START: cnt_q <= WIDTH'(1);
                T_STEP:  if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt = cnt_q;

    // R4
    timer_sat_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (op == T_STEP && cnt_q == LIM) |=> cnt_q == LIM);
endmodule

// File: rtl/pwr_seq_outdec.sv
module pwr_seq_outdec
    import pwr_seq_pkg::*;
#(
    parameter int CW              = 8,
    parameter int CORE_RST_CYCLES = 16
) (
    input  seq_state_t    state,
    input  logic [CW-1:0] cnt,
    output logic          osc_en,
    output logic          pad_oe,
    output logic          core_rst,
    output logic          run,
    output logic          msg_ok
);
    localparam logic [CW-1:0] CORE_LIM = CW'(CORE_RST_CYCLES);

    always_comb begin
        osc_en   = 1'b0;
        pad_oe   = 1'b0;
        core_rst = 1'b1;
        run      = 1'b0;
        msg_ok   = 1'b0;
        unique case (state)
            ST_SLEEP: begin
            end
            ST_WAIT_RST: begin
                osc_en = 1'b1;
                pad_oe = 1'b1;
            end
            ST_INIT: begin
                osc_en   = 1'b1;
                pad_oe   = 1'b1;
                core_rst = (cnt < CORE_LIM);
            end
            ST_RUN: begin
                osc_en   = 1'b1;
                pad_oe   = 1'b1;
                core_rst = 1'b0;
                run      = 1'b1;
                msg_ok   = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int STAB_CYCLES     = 192000,
    parameter int INIT_CYCLES     = 480000,
    parameter int CORE_RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_in_n,
    input  logic pdn_n,
    output logic osc_en,
    output logic pad_oe,
    output logic core_rst,
    output logic run,
    output logic msg_ok
);
    localparam int CNT_MAX = (STAB_CYCLES > INIT_CYCLES) ? STAB_CYCLES : INIT_CYCLES;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] STAB_LIM = CW'(STAB_CYCLES);
    localparam logic [CW-1:0] INIT_END = CW'(INIT_CYCLES - 1);

    seq_state_t    state_q, state_d;
    tmr_op_t       t_op;
    logic [CW-1:0] cnt_q;
    logic          rst_s;

    pwr_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .arst_n(pdn_n), .d(rst_in_n), .q(rst_s)
    );

    pwr_seq_timer #(.WIDTH(CW), .MAX(CNT_MAX)) u_timer (
        .clk(clk), .arst_n(pdn_n), .op(t_op), .cnt(cnt_q)
    );

    // state register: power-down is the asynchronous sleep entry
    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) state_q <= ST_SLEEP;
        else        state_q <= state_d;
    end

    // next state and timer command
    always_comb begin
        state_d = state_q;
        t_op    = T_HOLD;
        unique case (state_q)
            ST_SLEEP: begin
                if (!rst_s) begin
                    state_d = ST_WAIT_RST;
                    t_op    = T_START;
                end
            end
            ST_WAIT_RST: begin
                if (!rst_s) begin
                    t_op = T_STEP;
                end else if (cnt_q >= STAB_LIM) begin
                    state_d = ST_INIT;
                    t_op    = T_CLEAR;
                end else begin
                    t_op = T_CLEAR;
                end
            end
            ST_INIT: begin
                if (!rst_s) begin
                    state_d = ST_WAIT_RST;
                    t_op    = T_START;
                end else if (cnt_q == INIT_END) begin
                    state_d = ST_RUN;
                    t_op    = T_CLEAR;
                end else begin
                    t_op = T_STEP;
                end
            end
            ST_RUN: begin
                if (!rst_s) begin
                    state_d = ST_WAIT_RST;
                    t_op    = T_START;
                end
            end
            default: begin
                state_d = ST_SLEEP;
                t_op    = T_CLEAR;
            end
        endcase
    end

    pwr_seq_outdec #(.CW(CW), .CORE_RST_CYCLES(CORE_RST_CYCLES)) u_outdec (
        .state(state_q), .cnt(cnt_q),
        .osc_en(osc_en), .pad_oe(pad_oe), .core_rst(core_rst),
        .run(run), .msg_ok(msg_ok)
    );

    // R2
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        (state_q == ST_SLEEP && rst_s) |=> (state_q == ST_SLEEP && !osc_en));

    // R4
    short_reject_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        (state_q == ST_WAIT_RST && rst_s && cnt_q < STAB_LIM) |=> (state_q == ST_WAIT_RST && core_rst));

    // R5
    init_entry_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        (state_q == ST_INIT && $past(state_q) == ST_WAIT_RST) |-> $past(cnt_q) >= STAB_LIM);

    // R5
    core_release_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        $fell(core_rst) |-> (state_q == ST_INIT && osc_en));

    // R6
    run_entry_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        $rose(run) |-> ($past(state_q) == ST_INIT && !$past(core_rst)));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        ((state_q == ST_INIT || state_q == ST_RUN) && !rst_s) |=> (core_rst && !run && osc_en));
endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
    localparam int S    = 2;
    localparam int STAB = 20;
    localparam int INIT = 40;
    localparam int CORE = 16;

    logic clk = 1'b0;
    logic rst_in_n = 1'b1;
    logic pdn_n = 1'b0;
    logic osc_en, pad_oe, core_rst, run, msg_ok;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_seq_ctrl #(.SYNC_STAGES(S), .STAB_CYCLES(STAB), .INIT_CYCLES(INIT),
                   .CORE_RST_CYCLES(CORE)) i_pwr_seq_ctrl (
        .clk(clk), .rst_in_n(rst_in_n), .pdn_n(pdn_n),
        .osc_en(osc_en), .pad_oe(pad_oe), .core_rst(core_rst),
        .run(run), .msg_ok(msg_ok)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // reference model: 0 sleep, 1 wait, 2 init, 3 run
    int m_st = 0;
    int m_cnt = 0;
    logic [S-1:0] m_sync = '1;

    always @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            m_st = 0; m_cnt = 0; m_sync = '1;
        end else begin
            logic rs;
            rs = m_sync[S-1];
            m_sync = {m_sync[S-2:0], rst_in_n};
            case (m_st)
                0: if (!rs) begin m_st = 1; m_cnt = 1; end
                1: begin
                    if (!rs) begin if (m_cnt < INIT) m_cnt++; end
                    else if (m_cnt >= STAB) begin m_st = 2; m_cnt = 0; end
                    else m_cnt = 0;
                end
                2: begin
                    if (!rs) begin m_st = 1; m_cnt = 1; end
                    else if (m_cnt == INIT - 1) begin m_st = 3; m_cnt = 0; end
                    else m_cnt++;
                end
                default: if (!rs) begin m_st = 1; m_cnt = 1; end
            endcase
        end
    end

    function automatic logic [4:0] exp_outs(input int st, input int cnt);
        // {osc_en, pad_oe, core_rst, run, msg_ok}
        case (st)
            0: return 5'b00100;
            1: return 5'b11100;
            2: return {2'b11, (cnt < CORE) ? 1'b1 : 1'b0, 2'b00};
            default: return 5'b11011;
        endcase
    endfunction

    always @(negedge clk) begin
        #2;
        if (!done) begin
            logic [4:0] e;
            e = exp_outs(m_st, m_cnt);
            chk(osc_en == e[4], (m_st == 0) ? "R1" : "R3", "osc_en", osc_en, e[4]);
            chk(pad_oe == e[3], (m_st == 0) ? "R1" : "R3", "pad_oe", pad_oe, e[3]);
            chk(core_rst == e[2], "R5", "core_rst", core_rst, e[2]);
            chk(run == e[1], "R6", "run", run, e[1]);
            chk(msg_ok == e[0], "R6", "msg_ok", msg_ok, e[0]);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rst(input int n);
        @(negedge clk);
        rst_in_n = 1'b0;
        repeat (n) @(negedge clk);
        rst_in_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        idle(5);
        #2;
        // R1 reset state under power-down
        chk(osc_en == 0 && pad_oe == 0 && core_rst == 1 && run == 0 && msg_ok == 0,
            "R1", "sleep outputs", {osc_en, pad_oe, core_rst, run, msg_ok}, 5'b00100);
        @(negedge clk); pdn_n = 1'b1;
        idle(30);
        #2;
        // R2 power-down release alone does not wake
        chk(osc_en == 0 && run == 0, "R2", "asleep after pdn high", osc_en, 0);
        // R4 short pulse rejected
        pulse_rst(STAB - 1);
        idle(4);
        #2;
        chk(osc_en == 1 && core_rst == 1, "R3", "wait state outputs", {osc_en, core_rst}, 2'b11);
        idle(INIT + 20);
        #2;
        chk(core_rst == 1 && run == 0, "R4", "short pulse ignored", run, 0);
        // R5 exact-length pulse qualifies
        pulse_rst(STAB);
        idle(S + 2);
        #2;
        chk(core_rst == 1 && run == 0, "R5", "core reset in early init", core_rst, 1);
        idle(CORE + 2);
        #2;
        chk(core_rst == 0 && run == 0, "R5", "core released before run", core_rst, 0);
        idle(INIT);
        #2;
        chk(run == 1 && msg_ok == 1, "R6", "running after init", run, 1);
        // R7 restart from RUN
        pulse_rst(25);
        #2;
        chk(run == 0 && core_rst == 1 && osc_en == 1, "R7", "restart clears run", run, 0);
        idle(INIT + 10);
        #2;
        chk(run == 1, "R6", "running again", run, 1);
        // R8 asynchronous sleep entry
        @(negedge clk); pdn_n = 1'b0;
        #2;
        chk(osc_en == 0 && pad_oe == 0 && run == 0, "R8", "async sleep", osc_en, 0);
        idle(3); pdn_n = 1'b1;
        idle(10);
        #2;
        chk(osc_en == 0, "R2", "stays asleep after second pdn", osc_en, 0);

        // random mix checked by the cycle model
        for (int i = 0; i < 60; i++) begin
            int act;
            act = int'($urandom % 10);
            if (act < 6) begin
                pulse_rst(1 + int'($urandom % 30));
            end else if (act < 8) begin
                @(negedge clk); pdn_n = 1'b0;
                idle(1 + int'($urandom % 6));
                pdn_n = 1'b1;
            end
            idle(int'($urandom % 70));
        end
        idle(5);
        finish_run();
    end
endmodule